// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives 8-bit characters from an asynchronous serial line. The system clock is divided by a 16-bit divisor to make a sampling tick at sixteen times the bit rate. The receiver hunts for a start bit and checks it on a run of consecutive low ticks, so that short low glitches are rejected. It then samples every bit at its nominal centre and delivers each character with a ready flag and two error flags.

Three single-cycle commands control the receiver. Enable starts the hunt for a start bit. Disable stops the receiver, but a character that is already in flight is allowed to finish first. Reset stops the receiver at once and drops any partial character. Software clears the ready flag by pulsing a read-acknowledge input.

Top module: `oversampled_rx`

## Requirements
- R1: After reset, `rxEnabled`, `rxReady`, `overrun` and `frameErr` are all 0. A character sent on `rxLine` before any enable command is not received.
- R2: After an enable command, `rxEnabled` is 1 and the receiver hunts for a start bit. A frame is one low start bit, then 8 data bits sent LSB first, then one high stop bit, with every bit lasting 16 ticks. The byte appears on `rxData` with `rxReady` set to 1.
- R3: A low level that lasts 7 sampling ticks or fewer is ignored. A low level that lasts 8 or more ticks is taken as a start bit; held for 8 ticks and then released, it yields the byte 0xFF.
- R4: With `divisor` = N > 0, one sampling tick is produced every N clocks, so frames with a bit time of 16·N clocks are received correctly. With `divisor` = 0 no tick is produced and no character is received.
- R5: A disable command given while the receiver is hunting clears `rxEnabled` on the next cycle. Frames sent after that are not received.
- R6: A disable command given after a start bit has been accepted leaves `rxEnabled` at 1 until the stop bit has been sampled. The character is delivered, and then `rxEnabled` becomes 0.
- R7: A reset command clears `rxEnabled`, `rxReady`, `overrun` and `frameErr` at once, whatever the current state. A partial character is dropped and never delivered.
- R8: When a character completes, `frameErr` takes the value 1 if the stop-bit sample was low and 0 if it was high.
- R9: If a character completes while `rxReady` is still 1 and is not acknowledged in that cycle, `overrun` becomes 1 and `rxData` takes the new byte.
- R10: A `readAck` pulse clears `rxReady` and `overrun`. If `readAck` arrives in the same cycle that a character completes, `rxReady` stays 1 with the new byte and `overrun` stays 0.
- R11: When several commands arrive in the same cycle, reset wins over disable, and disable wins over enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clocks per sampling tick; 0 stops the tick |
| rxLine | input | 1 | Serial input line, idle high |
| cmdEnable | input | 1 | One-cycle enable command |
| cmdDisable | input | 1 | One-cycle disable command |
| cmdReset | input | 1 | One-cycle receiver reset command |
| readAck | input | 1 | One-cycle read acknowledge |
| rxData | output | 8 | Last received byte |
| rxReady | output | 1 | A byte is waiting to be read |
| overrun | output | 1 | A byte was overwritten before it was read |
| frameErr | output | 1 | The stop bit of the last byte was low |
| rxEnabled | output | 1 | The receiver is hunting or receiving |

## Verification
Character completion and `readAck` can fall in the same clock cycle. When they do, the new byte must win and no overrun may be reported.

The bench uses a divisor of 1, so that the tick is the clock and the timing is fixed. It first measures the exact cycle in which `rxReady` rises. It then repeats the same frame with the previous byte still unread and places a single `readAck` pulse on that measured cycle. The outputs are judged on the next falling edge: `rxReady` must be 1, `overrun` must be 0, and `rxData` must hold the new byte.

// File: rtl/orx_pkg.sv
package orx_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_HUNT, ST_RECV} rxState_t;

  typedef struct packed {
    logic sampleBit;   // shift one data bit in
    logic finishChar;  // stop bit sampled, publish character
    logic flush;       // receiver reset command
  } rxStrobe_t;
endpackage

// File: rtl/orx_tick.sv
module orx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      tick   <= 1'b0;
    end else if (divisor == '0) begin
      divCnt <= '0;
      tick   <= 1'b0;
    end else if (divCnt >= divisor - DIV_W'(1)) begin
      divCnt <= '0;
      tick   <= 1'b1;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
      tick   <= 1'b0;
    end
  end

  // R4: a zero divisor produces no tick
  a_r4_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> !tick);
endmodule

// File: rtl/orx_ctrl.sv
module orx_ctrl
  import orx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int START_MIN = 8,
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      lineIn,
  input  logic      cmdEnable,
  input  logic      cmdDisable,
  input  logic      cmdReset,
  output rxStrobe_t strobe,
  output logic      enabled
);
  localparam int FIRST_WAIT = OVS + OVS / 2 - START_MIN;
  localparam int TIMER_W    = $clog2(FIRST_WAIT + 1);
  localparam int LOW_W      = $clog2(START_MIN + 1);
  localparam int IDX_W      = $clog2(DATA_BITS + 1);

  rxState_t           state;
  logic [LOW_W-1:0]   lowCnt;
  logic [TIMER_W-1:0] timer;
  logic [IDX_W-1:0]   bitIdx;
  logic               stopPending;
  logic               atSample;
  logic               stopNext;

  always_comb begin
    atSample          = (state == ST_RECV) && tick && (timer == '0);
    strobe.sampleBit  = atSample && (bitIdx != IDX_W'(DATA_BITS)) && !cmdReset;
    strobe.finishChar = atSample && (bitIdx == IDX_W'(DATA_BITS)) && !cmdReset;
    strobe.flush      = cmdReset;
    stopNext          = cmdDisable ? 1'b1 : (cmdEnable ? 1'b0 : stopPending);
    enabled           = (state != ST_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_OFF;
      lowCnt      <= '0;
      timer       <= '0;
      bitIdx      <= '0;
      stopPending <= 1'b0;
    end else if (cmdReset) begin
      state       <= ST_OFF;
      lowCnt      <= '0;
      bitIdx      <= '0;
      stopPending <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          if (cmdEnable && !cmdDisable) begin
            state  <= ST_HUNT;
            lowCnt <= '0;
          end
        end
        ST_HUNT: begin
          if (cmdDisable) begin
            state <= ST_OFF;
          end else if (tick) begin
            if (!lineIn) begin
              if (lowCnt == LOW_W'(START_MIN - 1)) begin
                state       <= ST_RECV;
                timer       <= TIMER_W'(FIRST_WAIT);
                bitIdx      <= '0;
                stopPending <= 1'b0;
              end else begin
                lowCnt <= lowCnt + LOW_W'(1);
              end
            end else begin
              lowCnt <= '0;
            end
          end
        end
        ST_RECV: begin
          stopPending <= stopNext;
          if (atSample) begin
            timer <= TIMER_W'(OVS - 1);
            if (bitIdx == IDX_W'(DATA_BITS)) begin
              state       <= stopNext ? ST_OFF : ST_HUNT;
              lowCnt      <= '0;
              stopPending <= 1'b0;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end else if (tick) begin
            timer <= timer - TIMER_W'(1);
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  // R7: reset command disables on the next cycle
  a_r7_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
    cmdReset |=> !enabled);
  // R5: disable while hunting stops at once
  a_r5_hunt_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && cmdDisable) |=> !enabled);
  // R6: an accepted character is never cut short without a reset
  a_r6_finish_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV && !cmdReset && !strobe.finishChar) |=> enabled);
  // R11: disable beats enable while off
  a_r11_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && cmdEnable && cmdDisable) |=> !enabled);
endmodule

// File: rtl/orx_datapath.sv
module orx_datapath
  import orx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lineRaw,
  input  logic                 readAck,
  input  rxStrobe_t            strobe,
  output logic                 lineSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic                 overrun,
  output logic                 frameErr
);
  logic [1:0]           syncQ;
  logic [DATA_BITS-1:0] shiftReg;

  assign lineSync = syncQ[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b11;
    else        syncQ <= {syncQ[0], lineRaw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      rxData   <= '0;
      rxReady  <= 1'b0;
      overrun  <= 1'b0;
      frameErr <= 1'b0;
    end else if (strobe.flush) begin
      shiftReg <= '0;
      rxData   <= '0;
      rxReady  <= 1'b0;
      overrun  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobe.sampleBit)
        shiftReg <= {lineSync, shiftReg[DATA_BITS-1:1]};
      if (strobe.finishChar) begin
        rxData   <= shiftReg;
        frameErr <= ~lineSync;
        rxReady  <= 1'b1;
        overrun  <= rxReady && !readAck;
      end else if (readAck) begin
        rxReady <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  // R10: a lone acknowledge clears ready and overrun
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (readAck && !strobe.finishChar && !strobe.flush) |=> (!rxReady && !overrun));
  // R10: completion colliding with acknowledge keeps the new byte, no overrun
  a_r10_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (readAck && strobe.finishChar && !strobe.flush) |=> (rxReady && !overrun));
  // R9: overrun only rises on a character completion
  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(strobe.finishChar));
endmodule

// File: rtl/oversampled_rx.sv
module oversampled_rx
  import orx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int START_MIN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     divisor,
  input  logic                 rxLine,
  input  logic                 cmdEnable,
  input  logic                 cmdDisable,
  input  logic                 cmdReset,
  input  logic                 readAck,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic                 overrun,
  output logic                 frameErr,
  output logic                 rxEnabled
);
  logic      tick;
  logic      lineSync;
  rxStrobe_t strobe;

  orx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  orx_ctrl #(.OVS(OVS), .START_MIN(START_MIN), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lineIn(lineSync),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .strobe(strobe), .enabled(rxEnabled)
  );

  orx_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .lineRaw(rxLine), .readAck(readAck),
    .strobe(strobe), .lineSync(lineSync), .rxData(rxData),
    .rxReady(rxReady), .overrun(overrun), .frameErr(frameErr)
  );
endmodule

// File: tb/sim_oversampled_rx.sv
`timescale 1ns/1ps
module sim_oversampled_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd2;
  logic        rxLine = 1'b1;
  logic        cmdEnable = 1'b0, cmdDisable = 1'b0, cmdReset = 1'b0, readAck = 1'b0;
  logic [7:0]  rxData;
  logic        rxReady, overrun, frameErr, rxEnabled;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic       mReady = 1'b0;
  logic       mOv = 1'b0;
  logic [7:0] mData = 8'h00;
  logic       mFe = 1'b0;

  always #2.5 clk = ~clk;

  oversampled_rx u0 (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .rxLine(rxLine),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .readAck(readAck), .rxData(rxData), .rxReady(rxReady), .overrun(overrun),
    .frameErr(frameErr), .rxEnabled(rxEnabled)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // one frame: start, 8 data LSB first, stop; a low stop is released early
  task automatic sendChar(input logic [7:0] data, input logic stopVal, input int d);
    rxLine = 1'b0;
    waitClk(16 * d);
    for (int i = 0; i < 8; i++) begin
      rxLine = data[i];
      waitClk(16 * d);
    end
    rxLine = stopVal;
    if (stopVal) waitClk(16 * d);
    else begin
      waitClk(10 * d);
      rxLine = 1'b1;
      waitClk(6 * d);
    end
    rxLine = 1'b1;
    waitClk(4);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmdEnable = 1'b1;
      1: cmdDisable = 1'b1;
      2: cmdReset = 1'b1;
      default: readAck = 1'b1;
    endcase
    waitClk(1);
    cmdEnable = 1'b0; cmdDisable = 1'b0; cmdReset = 1'b0; readAck = 1'b0;
  endtask

  function automatic logic expectOverrun(input logic readyBefore);
    return readyBefore;
  endfunction

  task automatic checkOutputs(input string req);
    chk(req, "rxReady", rxReady, mReady);
    chk(req, "overrun", overrun, mOv);
    chk(req, "rxData", rxData, mData);
    chk(req, "frameErr", frameErr, mFe);
  endtask

  task automatic modelChar(input logic [7:0] d, input logic stopVal);
    mOv = expectOverrun(mReady);
    mReady = 1'b1;
    mData = d;
    mFe = ~stopVal;
  endtask

  task automatic ackAndCheck(input string req);
    pulse(3);
    mReady = 1'b0; mOv = 1'b0;
    chk(req, "rxReady after ack", rxReady, 0);
    chk(req, "overrun after ack", overrun, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int nMeas;
    bit found;
    void'($urandom(32'd20240611));
    waitClk(3);
    rst_n = 1'b1;
    waitClk(2);
    // R1 reset state
    chk("R1", "rxEnabled", rxEnabled, 0);
    checkOutputs("R1");
    sendChar(8'h5A, 1'b1, 2);
    chk("R1", "rxReady while off", rxReady, 0);

    // R2 enable and receive
    pulse(0);
    chk("R2", "rxEnabled", rxEnabled, 1);
    waitClk(20);
    sendChar(8'hA5, 1'b1, 2);
    modelChar(8'hA5, 1'b1);
    checkOutputs("R2");
    ackAndCheck("R10");

    // R3 glitch of 7 ticks ignored, 8 ticks accepted
    rxLine = 1'b0; waitClk(7 * 2); rxLine = 1'b1;
    waitClk(200 * 2);
    chk("R3", "rxReady after 7-tick low", rxReady, 0);
    rxLine = 1'b0; waitClk(8 * 2); rxLine = 1'b1;
    waitClk(200 * 2);
    modelChar(8'hFF, 1'b1);
    checkOutputs("R3");
    ackAndCheck("R10");

    // R8 framing error
    sendChar(8'h3C, 1'b0, 2);
    modelChar(8'h3C, 1'b0);
    checkOutputs("R8");
    ackAndCheck("R10");
    waitClk(40);
    sendChar(8'h3C, 1'b1, 2);
    modelChar(8'h3C, 1'b1);
    checkOutputs("R8");
    ackAndCheck("R10");

    // R9 overrun
    sendChar(8'h11, 1'b1, 2);
    modelChar(8'h11, 1'b1);
    sendChar(8'h22, 1'b1, 2);
    modelChar(8'h22, 1'b1);
    chk("R9", "overrun", overrun, 1);
    checkOutputs("R9");
    ackAndCheck("R10");

    // R5 disable while hunting
    pulse(1);
    chk("R5", "rxEnabled", rxEnabled, 0);
    sendChar(8'h66, 1'b1, 2);
    chk("R5", "rxReady while disabled", rxReady, 0);

    // R11 command priority
    cmdEnable = 1'b1; cmdDisable = 1'b1; waitClk(1);
    cmdEnable = 1'b0; cmdDisable = 1'b0;
    chk("R11", "enable+disable", rxEnabled, 0);
    cmdEnable = 1'b1; cmdReset = 1'b1; waitClk(1);
    cmdEnable = 1'b0; cmdReset = 1'b0;
    chk("R11", "enable+reset", rxEnabled, 0);

    // R6 disable mid-character
    pulse(0);
    waitClk(20);
    fork
      sendChar(8'h77, 1'b1, 2);
      begin
        waitClk(60 * 2);
        pulse(1);
        waitClk(2);
        chk("R6", "rxEnabled mid-frame", rxEnabled, 1);
      end
    join
    modelChar(8'h77, 1'b1);
    checkOutputs("R6");
    chk("R6", "rxEnabled after stop", rxEnabled, 0);
    ackAndCheck("R10");

    // R7 reset command mid-character
    pulse(0);
    waitClk(20);
    fork
      sendChar(8'h99, 1'b1, 2);
      begin
        waitClk(80 * 2);
        pulse(2);
        chk("R7", "rxEnabled", rxEnabled, 0);
      end
    join
    chk("R7", "rxReady after abort", rxReady, 0);
    chk("R7", "rxEnabled after abort", rxEnabled, 0);
    pulse(0);
    waitClk(20);
    sendChar(8'h42, 1'b1, 2);
    modelChar(8'h42, 1'b1);
    checkOutputs("R7");
    ackAndCheck("R10");

    // R4 zero divisor stops ticks
    divisor = 16'd0;
    waitClk(4);
    sendChar(8'h0F, 1'b1, 2);
    chk("R4", "rxReady with divisor 0", rxReady, 0);
    divisor = 16'd3;
    waitClk(60);
    sendChar(8'hF0, 1'b1, 3);
    modelChar(8'hF0, 1'b1);
    checkOutputs("R4");
    ackAndCheck("R10");

    // R10 collision: measure completion cycle with divisor 1
    divisor = 16'd1;
    waitClk(40);
    nMeas = 0; found = 0;
    readAck = 1'b1;
    fork
      sendChar(8'hC3, 1'b1, 1);
      begin
        for (int k = 1; k <= 160; k++) begin
          waitClk(1);
          if (rxReady && !found) begin
            found = 1; nMeas = k; readAck = 1'b0;
          end
        end
      end
    join
    readAck = 1'b0;
    chk("R10", "completion seen", found, 1);
    mReady = 1'b1; mOv = 1'b0; mData = 8'hC3; mFe = 1'b0;
    checkOutputs("R10");
    waitClk(40);
    fork
      sendChar(8'h3E, 1'b1, 1);
      begin
        if (nMeas > 1) begin
          waitClk(nMeas - 1);
          readAck = 1'b1;
          waitClk(1);
          readAck = 1'b0;
          chk("R10", "collision rxReady", rxReady, 1);
          chk("R10", "collision overrun", overrun, 0);
          chk("R10", "collision rxData", rxData, 8'h3E);
        end
      end
    join
    mData = 8'h3E;
    ackAndCheck("R10");

    // random frames with random divisors, acks and stop values
    for (int n = 0; n < 40; n++) begin
      int d;
      logic [7:0] b;
      logic sv;
      d = $urandom_range(1, 4);
      b = 8'($urandom);
      sv = ($urandom_range(0, 4) != 0);
      divisor = 16'(d);
      waitClk(20 * d);
      sendChar(b, sv, d);
      modelChar(b, sv);
      checkOutputs("R2");
      if ($urandom_range(0, 1) == 1) ackAndCheck("R10");
    end

    summary();
  end
endmodule